// File: doc/BRIEF.md
# Binary-Input Neuron with Threshold Decision

This block evaluates a single artificial neuron whose inputs are single bits. On a start request it walks through a vector of input bits and signed fixed-point weights held in two external synchronous memories. It sums the weights whose input bit is set, adds a bias, and passes the total through an external sigmoid lookup memory. The resulting activation is compared with two programmable thresholds. A two-bit code reports whether the neuron decided low, decided high or stayed undecided.

The surrounding system fills the three memories and writes four configuration registers through a shared value bus with one load strobe per register. It then pulses `start` and waits for `ready`. The datapath is a three-stage pipeline: memory read, gating multiply, then accumulate. Time from start to ready therefore grows by exactly one clock per input.

Top module: `bitvec_neuron`

## Requirements
- R1: Weights are 13-bit two's complement with 8 fraction bits. Each weight whose input bit reads 1 is added to the sum. A weight whose input bit reads 0 contributes nothing.
- R2: The input count N is the low 11 bits of `cfg_val` loaded with `ld_cnt`. Values above 1024 are clamped to 1024. N = 0 makes the total equal to the bias alone.
- R3: The accumulation and the bias addition saturate to +4095 or -4096. They never wrap.
- R4: `ready` rises exactly N + 13 clock edges after the edge that samples `start` in idle.
- R5: When the total lies in [-1024, 1023], `sig_addr` carries the total's low 11 bits in two's complement. The value read back on `sig_data` one cycle later is used as the activation.
- R6: A total below -1024 gives activation 0x00 and a total of 1024 or more gives 0xFF. Neither uses the lookup memory's data.
- R7: The result is 2'b00 when the activation is at or below min (this takes precedence). It is 2'b01 when the activation is at or above max, and 2'b10 otherwise. Min and max are the low 8 bits of `cfg_val` loaded with `ld_min` and `ld_max`.
- R8: After completion, `ready` and `result` hold until the next accepted start, and that start drops `ready`.
- R9: A `start` pulse while a run is in progress is ignored: there is no restart, no extra `ready` and no change of latency or result.
- R10: Synchronous reset returns the block to idle, with `ready` low and `result` 2'b00, including in the middle of a run.
- R11: The bias is the full 13 bits of `cfg_val` loaded with `ld_bias`. Configuration strobes during a run are ignored, and registers keep their value until reloaded while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation (honoured only in idle) |
| cfg_val | input | 13 | Value for the configuration register selected by a strobe |
| ld_bias | input | 1 | Load bias from cfg_val |
| ld_min | input | 1 | Load lower decision threshold from cfg_val[7:0] |
| ld_max | input | 1 | Load upper decision threshold from cfg_val[7:0] |
| ld_cnt | input | 1 | Load input count from cfg_val[10:0] |
| x_addr | output | 10 | Input-bit memory address |
| x_bit | input | 1 | Input-bit memory data, one cycle after address |
| w_addr | output | 10 | Weight memory address |
| w_data | input | 13 | Weight memory data, one cycle after address |
| sig_addr | output | 11 | Sigmoid memory address |
| sig_data | input | 8 | Sigmoid memory data, one cycle after address |
| ready | output | 1 | Result valid; held until the next start |
| result | output | 2 | Decision code |

## Verification
The bench targets three kinds of edge case.

- **Range and arithmetic.** It drives the lookup boundaries -1024, 1023 and 1024. An off-by-one range test there would return a saturated code where a table value is expected, or the reverse. It also drives sums far past the 13-bit range: a wrapping accumulator would flip their sign and invert the decision.
- **Thresholds.** It sets activations exactly equal to each threshold, and sets min above max. A design with strict comparisons or the wrong precedence would report the wrong code.
- **Count and timing.** It uses a zero count, an over-range count, and stray `start` and load strobes during a run. A design that mishandles these would run the wrong number of inputs, change its latency, pulse `ready` twice or take a new bias mid-run.

// File: rtl/bneuron_pkg.sv
package bneuron_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CFGD,
    S_CFGB,
    S_ISSUE,
    S_DRAIN,
    S_SUM,
    S_LUT,
    S_CMP
  } nstate_e;

  localparam logic [1:0] RES_LOW   = 2'b00;
  localparam logic [1:0] RES_HIGH  = 2'b01;
  localparam logic [1:0] RES_UNDEC = 2'b10;

endpackage

// File: rtl/bneuron_ctrl.sv
module bneuron_ctrl
  import bneuron_pkg::*;
#(
  parameter int AW       = 10,
  parameter int CW       = 11,
  parameter int CFG_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] n_inputs,
  output logic          issue_vld,
  output logic [AW-1:0] issue_idx,
  output logic          acc_clr,
  output logic          sum_ld,
  output logic          cmp_ld,
  output logic          ready,
  output logic          busy
);

  localparam int DRAIN_CYC = 2;
  localparam int WCW       = $clog2(CFG_WAIT) + 2;
  localparam int LAT_FIX   = 2 * CFG_WAIT + DRAIN_CYC + 3;
  localparam int LCW       = CW + 3;

  nstate_e        st;
  logic [WCW-1:0] wcnt;
  logic [AW-1:0]  idx;

  // named events for checks and datapath control
  wire accept     = (st == S_IDLE) && start;
  wire cfg_done   = (wcnt == WCW'(CFG_WAIT - 1));
  wire drain_done = (wcnt == WCW'(DRAIN_CYC - 1));
  wire last_issue = (CW'(idx) == (n_inputs - CW'(1)));
  wire no_inputs  = (n_inputs == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      wcnt  <= '0;
      idx   <= '0;
      ready <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            st    <= S_CFGD;
            wcnt  <= '0;
            ready <= 1'b0;
          end
        end
        S_CFGD: begin
          if (cfg_done) begin
            st   <= S_CFGB;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + WCW'(1);
          end
        end
        S_CFGB: begin
          if (cfg_done) begin
            wcnt <= '0;
            idx  <= '0;
            st   <= no_inputs ? S_DRAIN : S_ISSUE;
          end else begin
            wcnt <= wcnt + WCW'(1);
          end
        end
        S_ISSUE: begin
          if (last_issue) begin
            st   <= S_DRAIN;
            wcnt <= '0;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        S_DRAIN: begin
          if (drain_done) st <= S_SUM;
          else            wcnt <= wcnt + WCW'(1);
        end
        S_SUM: st <= S_LUT;
        S_LUT: st <= S_CMP;
        S_CMP: begin
          st    <= S_IDLE;
          ready <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign issue_vld = (st == S_ISSUE);
  assign issue_idx = idx;
  assign acc_clr   = accept;
  assign sum_ld    = (st == S_SUM);
  assign cmp_ld    = (st == S_CMP);
  assign busy      = (st != S_IDLE);

  // cycle counter since the accepted start, for the latency check
  logic [LCW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst)         lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy)   lat_cnt <= lat_cnt + LCW'(1);
  end

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (lat_cnt == (LCW'(n_inputs) + LCW'(LAT_FIX))));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(st == S_CFGD && wcnt == '0));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> ready);

endmodule

// File: rtl/bneuron_mac.sv
module bneuron_mac #(
  parameter int WW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_clr,
  input  logic          issue_vld,
  input  logic          x_bit,
  input  logic [WW-1:0] w_data,
  input  logic          sum_ld,
  input  logic [WW-1:0] bias,
  output logic [WW-1:0] total
);

  localparam logic [WW-1:0] POS_MAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] NEG_MAX = {1'b1, {(WW-1){1'b0}}};

  function automatic logic [WW-1:0] sat_add(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW:0] s;
    s = {a[WW-1], a} + {b[WW-1], b};
    if (s[WW] != s[WW-1]) return s[WW] ? NEG_MAX : POS_MAX;
    return s[WW-1:0];
  endfunction

  logic          rd_vld;   // memory data valid this cycle
  logic          prod_vld; // product register valid
  logic [WW-1:0] prod;
  logic [WW-1:0] acc;

  // 1 x WW multiply: gate the weight by the input bit
  wire [WW-1:0] gated = x_bit ? w_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld   <= 1'b0;
      prod_vld <= 1'b0;
      prod     <= '0;
      acc      <= '0;
      total    <= '0;
    end else begin
      rd_vld   <= issue_vld;
      prod_vld <= rd_vld;
      prod     <= rd_vld ? gated : '0;
      if (acc_clr)       acc <= '0;
      else if (prod_vld) acc <= sat_add(acc, prod);
      if (sum_ld) total <= sat_add(acc, bias);
    end
  end

  // R3
  pos_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_vld && !acc_clr && !prod[WW-1] && !acc[WW-1]) |=> !acc[WW-1]);

  // R3
  neg_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_vld && !acc_clr && prod[WW-1] && acc[WW-1]) |=> acc[WW-1]);

endmodule

// File: rtl/bneuron_activ.sv
module bneuron_activ
  import bneuron_pkg::*;
#(
  parameter int WW  = 13,
  parameter int SW  = 8,
  parameter int LAW = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmp_ld,
  input  logic [WW-1:0]  total,
  input  logic [SW-1:0]  thr_min,
  input  logic [SW-1:0]  thr_max,
  input  logic [SW-1:0]  sig_data,
  output logic [LAW-1:0] sig_addr,
  output logic [1:0]     result
);

  localparam int HB = WW - LAW + 1;

  function automatic logic [1:0] decide(input logic [SW-1:0] s, input logic [SW-1:0] mn,
                                        input logic [SW-1:0] mx);
    if (s <= mn) return RES_LOW;
    if (s >= mx) return RES_HIGH;
    return RES_UNDEC;
  endfunction

  wire [HB-1:0] top_bits = total[WW-1:LAW-1];
  wire          in_range = (top_bits == '0) || (top_bits == '1);
  wire          sat_lo   = total[WW-1] && !in_range;
  wire          sat_hi   = !total[WW-1] && !in_range;

  assign sig_addr = {total[WW-1], total[LAW-2:0]};

  wire [SW-1:0] sig_val = sat_lo ? '0 : (sat_hi ? '1 : sig_data);

  always_ff @(posedge clk) begin
    if (rst)         result <= RES_LOW;
    else if (cmp_ld) result <= decide(sig_val, thr_min, thr_max);
  end

  // R6
  sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_ld && sat_lo) |=> (result == RES_LOW));

  // R6
  sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_ld && sat_hi && (thr_min != '1)) |=> (result == RES_HIGH));

  // R7
  code_chk: assert property (@(posedge clk) disable iff (rst)
    result != 2'b11);

endmodule

// File: rtl/bitvec_neuron.sv
module bitvec_neuron
  import bneuron_pkg::*;
#(
  parameter int MAX_N    = 1024,
  parameter int WW       = 13,
  parameter int SW       = 8,
  parameter int LAW      = 11,
  parameter int CFG_WAIT = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [WW-1:0]              cfg_val,
  input  logic                       ld_bias,
  input  logic                       ld_min,
  input  logic                       ld_max,
  input  logic                       ld_cnt,
  output logic [$clog2(MAX_N)-1:0]   x_addr,
  input  logic                       x_bit,
  output logic [$clog2(MAX_N)-1:0]   w_addr,
  input  logic [WW-1:0]              w_data,
  output logic [LAW-1:0]             sig_addr,
  input  logic [SW-1:0]              sig_data,
  output logic                       ready,
  output logic [1:0]                 result
);

  localparam int AW = $clog2(MAX_N);
  localparam int CW = AW + 1;

  function automatic logic [CW-1:0] fit_count(input logic [CW-1:0] c);
    return (c > CW'(MAX_N)) ? CW'(MAX_N) : c;
  endfunction

  logic [WW-1:0] bias_q;
  logic [SW-1:0] min_q;
  logic [SW-1:0] max_q;
  logic [CW-1:0] cnt_q;

  logic          busy;
  logic          issue_vld;
  logic [AW-1:0] issue_idx;
  logic          acc_clr;
  logic          sum_ld;
  logic          cmp_ld;
  logic [WW-1:0] total;

  always_ff @(posedge clk) begin
    if (rst) begin
      bias_q <= '0;
      min_q  <= '0;
      max_q  <= '1;
      cnt_q  <= '0;
    end else if (!busy) begin
      if (ld_bias) bias_q <= cfg_val;
      if (ld_min)  min_q  <= cfg_val[SW-1:0];
      if (ld_max)  max_q  <= cfg_val[SW-1:0];
      if (ld_cnt)  cnt_q  <= fit_count(cfg_val[CW-1:0]);
    end
  end

  bneuron_ctrl #(.AW(AW), .CW(CW), .CFG_WAIT(CFG_WAIT)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .n_inputs  (cnt_q),
    .issue_vld (issue_vld),
    .issue_idx (issue_idx),
    .acc_clr   (acc_clr),
    .sum_ld    (sum_ld),
    .cmp_ld    (cmp_ld),
    .ready     (ready),
    .busy      (busy)
  );

  assign x_addr = issue_idx;
  assign w_addr = issue_idx;

  bneuron_mac #(.WW(WW)) mac_i (
    .clk       (clk),
    .rst       (rst),
    .acc_clr   (acc_clr),
    .issue_vld (issue_vld),
    .x_bit     (x_bit),
    .w_data    (w_data),
    .sum_ld    (sum_ld),
    .bias      (bias_q),
    .total     (total)
  );

  bneuron_activ #(.WW(WW), .SW(SW), .LAW(LAW)) activ_i (
    .clk      (clk),
    .rst      (rst),
    .cmp_ld   (cmp_ld),
    .total    (total),
    .thr_min  (min_q),
    .thr_max  (max_q),
    .sig_data (sig_data),
    .sig_addr (sig_addr),
    .result   (result)
  );

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(bias_q) && $stable(cnt_q)));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_N));

endmodule

// File: tb/bitvec_neuron_tb_top.sv
module bitvec_neuron_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [12:0] cfg_val = '0;
  logic        ld_bias = 1'b0, ld_min = 1'b0, ld_max = 1'b0, ld_cnt = 1'b0;
  logic [9:0]  x_addr, w_addr;
  logic        x_bit;
  logic [12:0] w_data;
  logic [10:0] sig_addr;
  logic [7:0]  sig_data;
  logic        ready;
  logic [1:0]  result;

  always #5 clk = ~clk;

  bitvec_neuron dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_val(cfg_val),
    .ld_bias(ld_bias), .ld_min(ld_min), .ld_max(ld_max), .ld_cnt(ld_cnt),
    .x_addr(x_addr), .x_bit(x_bit), .w_addr(w_addr), .w_data(w_data),
    .sig_addr(sig_addr), .sig_data(sig_data), .ready(ready), .result(result)
  );

  // memory models
  logic        xm [1024];
  logic [12:0] wm [1024];

  function automatic int sig_fn(int a11);
    int u;
    u = (a11 & 2047) ^ 1024;
    return 1 + (u * 253) / 2047;
  endfunction

  always @(posedge clk) begin
    x_bit    <= xm[x_addr];
    w_data   <= wm[w_addr];
    sig_data <= 8'(sig_fn(int'(sig_addr)));
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench-side configuration model
  int bias_m = 0, min_m = 0, max_m = 255, cnt_m = 0;

  function automatic int sat13(int v);
    if (v > 4095) return 4095;
    if (v < -4096) return -4096;
    return v;
  endfunction

  function automatic int total_of();
    int acc = 0;
    for (int k = 0; k < cnt_m; k++)
      if (xm[k]) acc = sat13(acc + int'($signed(wm[k])));
    return sat13(acc + bias_m);
  endfunction

  function automatic int act_of(int tot);
    if (tot < -1024) return 0;
    if (tot > 1023) return 255;
    return sig_fn(tot);
  endfunction

  function automatic int code_of(int s);
    if (s <= min_m) return 0;
    if (s >= max_m) return 1;
    return 2;
  endfunction

  // scoreboard queues
  int    exp_res_q[$];
  int    exp_lat_q[$];
  int    st_cyc_q[$];
  string tag_q[$];
  int    last_res = 0;

  task automatic load(int kind, int v, bit model);
    @(negedge clk);
    cfg_val = 13'(v);
    ld_bias = (kind == 0); ld_min = (kind == 1);
    ld_max  = (kind == 2); ld_cnt = (kind == 3);
    @(negedge clk);
    ld_bias = 0; ld_min = 0; ld_max = 0; ld_cnt = 0;
    if (model) begin
      case (kind)
        0: bias_m = int'($signed(13'(v)));
        1: min_m = v & 255;
        2: max_m = v & 255;
        default: cnt_m = ((v & 2047) > 1024) ? 1024 : (v & 2047);
      endcase
    end
  endtask

  task automatic set_cfg(int n, int b, int mn, int mx);
    load(3, n, 1); load(0, b, 1); load(1, mn, 1); load(2, mx, 1);
  endtask

  // poke: 0 none, 1 stray start, 2 stray bias load
  task automatic run_case(string tag, int poke);
    exp_res_q.push_back(code_of(act_of(total_of())));
    exp_lat_q.push_back(cnt_m + 13);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1;
    st_cyc_q.push_back(cyc + 1);
    @(negedge clk);
    start = 0;
    if (poke == 1) begin
      repeat (4) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end else if (poke == 2) begin
      repeat (3) @(negedge clk);
      load(0, 4095, 0);
    end
    while (exp_res_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8: ready and result hold after completion
    chk({tag, " R8 ready held"}, int'(ready), 1);
    chk({tag, " R8 result held"}, int'(result), last_res);
  endtask

  // monitor
  bit rdy_prev = 0;
  always @(negedge clk) begin
    if (rst) begin
      rdy_prev = 0;
    end else begin
      if (ready && !rdy_prev) begin
        if (exp_res_q.size() == 0) begin
          chk("R9 unexpected ready", 1, 0);
        end else begin
          int er, el, sc;
          string tg;
          er = exp_res_q.pop_front();
          el = exp_lat_q.pop_front();
          sc = st_cyc_q.pop_front();
          tg = tag_q.pop_front();
          last_res = er;
          chk({tg, " result"}, int'(result), er);
          chk({tg, " R4 latency"}, cyc - sc, el);
        end
      end
      rdy_prev = ready;
    end
  end

  task automatic fill(int n, int xpat, int w);
    for (int k = 0; k < 1024; k++) begin
      xm[k] = (k < n) ? xpat[k % 32] : 1'b0;
      wm[k] = 13'(w);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    fill(1024, 0, 0);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready after reset", int'(ready), 0);
    chk("R10 result after reset", int'(result), 0);

    // R1 R5 R7: all bits set, total +0.5 -> undecided
    fill(4, 32'hF, 256);
    set_cfg(4, -896, 8'h61, 8'h9F);
    run_case("R1 R5 and4", 0);

    // R1: zero bits contribute nothing
    fill(4, 32'h5, 256);
    run_case("R1 zero bits", 0);

    // R2: empty vector, bias only
    set_cfg(0, 300, 8'h61, 8'h9F);
    run_case("R2 zero count", 0);

    // R3 R6: positive saturation
    fill(8, 32'hFF, 4095);
    set_cfg(8, 4095, 8'h61, 8'h9F);
    run_case("R3 R6 pos sat", 0);

    // R3 R6: negative saturation
    fill(8, 32'hFF, -4096);
    set_cfg(8, -4096, 0, 8'h9F);
    run_case("R3 R6 neg sat", 0);

    // R5 R6: lookup range boundaries
    fill(1, 32'h1, -1024);
    set_cfg(1, 0, 0, 255);
    run_case("R5 at -4", 0);
    fill(1, 32'h1, 1023);
    run_case("R5 below +4", 0);
    fill(1, 32'h1, 1024);
    run_case("R6 at +4", 0);

    // R7: min above max, min wins
    fill(4, 32'hF, 256);
    set_cfg(4, -896, 8'hF0, 8'h10);
    run_case("R7 precedence", 0);

    // R7: activation equal to thresholds
    load(1, act_of(total_of()), 1); load(2, 8'hF0, 1);
    run_case("R7 eq min", 0);
    load(1, 8'h10, 1); load(2, act_of(total_of()), 1);
    run_case("R7 eq max", 0);

    // R9: stray start mid-run
    set_cfg(4, -896, 8'h61, 8'h9F);
    run_case("R9 stray start", 1);

    // R11: bias strobe during run ignored, now and for next run
    run_case("R11 busy load", 2);
    run_case("R11 after busy load", 0);

    // R2 R4: over-range count clamps to 1024
    for (int k = 0; k < 1024; k++) begin
      xm[k] = (k % 5) != 3;
      wm[k] = (k % 3 == 0) ? 13'(3) : 13'(-1);
    end
    set_cfg(2000, -40, 8'h20, 8'hE0);
    run_case("R2 clamp", 0);

    // R10: reset mid-run
    fill(4, 32'hF, 256);
    set_cfg(4, -896, 8'h61, 8'h9F);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    repeat (20) @(negedge clk);
    chk("R10 ready after mid reset", int'(ready), 0);
    chk("R10 result after mid reset", int'(result), 0);
    bias_m = 0; min_m = 0; max_m = 255; cnt_m = 0;
    set_cfg(4, -896, 8'h61, 8'h9F);
    run_case("R10 run after reset", 0);

    finish_run();
  end

endmodule